// File: doc/BRIEF.md
# Partial Reconfiguration Host Controller

This block is the register front end that software uses to drive a partial-reconfiguration engine. Software talks to it with single-cycle 64-bit register writes and combinational reads over five word addresses: a header, a control word, a status word, an error word and a data port. Through these it runs a reset handshake and opens an operation on a chosen target region. It then streams 32-bit bitstream words into an internal word FIFO, closes the operation with a push-complete request and finally collects per-cause error bits.

Words leave the FIFO on a valid/ready stream towards a configuration sink. The status word shows a credit count equal to the free FIFO slots, and software paces its data writes on it. Once software has asked for push-complete and the FIFO has drained, the block signals the sink that the stream is over. When the sink reports that it has finished, the block withdraws the start request by itself and latches the sink's error code into the error word.

Top module: `prc_host`

## Requirements
- R1: After reset the control word reads 0, the status word shows host state IDLE (code 0 in bits 1:0), no error flag (bit 2) and a credit (bits 16 and up) equal to the FIFO depth, and the error word reads 0.
- R2: Writing control bit 0 (reset request) as 1 puts the host state at RESET (code 1), empties the FIFO and restores full credit, and control bit 1 (reset acknowledge) reads 1 from the second cycle after the write. Writing bit 0 as 0 returns the host state to IDLE, and the acknowledge drops one cycle later.
- R3: In IDLE, a control write with bit 8 (start) set opens an operation. The host state becomes LOAD (code 2), control bit 8 reads 1, and the region field (control bits 16 and up) and the `snk_region` output both take the written region.
- R4: In LOAD with credit above 0, a data write whose 64 bits are not all zero queues its low 32 bits and lowers the credit by one. Queued words leave on the sink stream in write order and are held stable while `snk_ready` is low.
- R5: Each sink handshake (`snk_valid` and `snk_ready` both high) raises the credit by one, and the credit never exceeds the FIFO depth.
- R6: An accepted all-zero data write (padding) reaches neither the FIFO nor the sink. It does not change the credit and raises no error.
- R7: A data write made outside LOAD, or made with zero credit, is dropped and sets error bit 0 (protocol overflow), which also sets the status error flag.
- R8: In LOAD, a control write with bit 9 (push complete) set moves the host state to DRAIN (code 3), and control bits 8 and 9 then read 1. `snk_push_done` is high exactly while the state is DRAIN and the FIFO is empty. A `snk_finish` pulse at that point returns the state to IDLE and clears bits 8 and 9.
- R9: On the finishing cycle, a nonzero `snk_err_code` k sets error bit k, and code 0 sets no error bit.
- R10: Writing the error word clears each bit written as 1. A bit that is being set in the same cycle stays set.
- R11: The header word reads the revision parameter in bits 7:0, whose default is 1. Any value other than 2 denotes a 4-byte data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: 0 header, 1 control, 2 status, 3 error, 4 data |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| snk_valid | output | 1 | Stream word available |
| snk_ready | input | 1 | Sink takes the word |
| snk_data | output | 32 | Stream word |
| snk_region | output | REGION_W | Target region of the operation |
| snk_push_done | output | 1 | Stream ended and drained |
| snk_finish | input | 1 | Sink finished the operation (pulse) |
| snk_err_code | input | ERR_CODE_W | Sink error cause, 0 for none |

## Verification
Two collisions are provoked on purpose. In the first, the sink's finish pulse carries error code 2 in the very cycle that software writes a one to error bit 2, and the bench expects the bit to read back as set. In the second, data writes keep arriving while the sink drains the FIFO with `snk_ready` toggling, so pushes and handshakes fall on the same edges. A behavioural model with a word queue and a credit counter then judges every cycle's stream output and every read of the status word.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_RESET = 2'd1,
    HS_LOAD  = 2'd2,
    HS_DRAIN = 2'd3
  } hstate_e;

  localparam logic [2:0] A_HDR  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_ERR  = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;

  localparam int C_RST    = 0;
  localparam int C_ACK    = 1;
  localparam int C_START  = 8;
  localparam int C_PUSH   = 9;
  localparam int C_REG_LO = 16;

  localparam int S_ERRF   = 2;
  localparam int S_CRD_LO = 16;
endpackage

// File: rtl/prc_word_fifo.sv
module prc_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = step(wptr_q);
      if (pop)  rptr_d = step(rptr_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
endmodule

// File: rtl/prc_err_log.sv
module prc_err_log #(
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] set_vec,
  input  logic [EW-1:0] clr_vec,
  output logic [EW-1:0] err_q
);
  logic [EW-1:0] err_d;

  always_comb err_d = (err_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end
endmodule

// File: rtl/prc_seq.sv
module prc_seq
  import prc_pkg::*;
#(
  parameter int REGION_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic                wr_rst,
  input  logic                wr_start,
  input  logic                wr_push,
  input  logic [REGION_W-1:0] wr_region,
  input  logic                fifo_empty,
  input  logic                snk_finish,
  output hstate_e             state_q,
  output logic [REGION_W-1:0] region_q,
  output logic                rst_req_q,
  output logic                ack_q,
  output logic                flush,
  output logic                finish_ok
);
  hstate_e             state_d;
  logic [REGION_W-1:0] region_d;
  logic                rst_req_d;

  assign flush     = ctrl_wr && wr_rst;
  assign finish_ok = (state_q == HS_DRAIN) && fifo_empty && snk_finish;

  always_comb begin
    state_d   = state_q;
    region_d  = region_q;
    rst_req_d = ctrl_wr ? wr_rst : rst_req_q;
    if (flush) begin
      state_d = HS_RESET;
    end else begin
      case (state_q)
        HS_RESET: if (ctrl_wr) state_d = HS_IDLE;
        HS_IDLE:  if (ctrl_wr && wr_start) begin
                    state_d  = HS_LOAD;
                    region_d = wr_region;
                  end
        HS_LOAD:  if (ctrl_wr && wr_push) state_d = HS_DRAIN;
        HS_DRAIN: if (finish_ok) state_d = HS_IDLE;
        default:  state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      region_q  <= '0;
      rst_req_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      region_q  <= region_d;
      rst_req_q <= rst_req_d;
      ack_q     <= rst_req_q;
    end
  end
endmodule

// File: rtl/prc_host.sv
module prc_host
  import prc_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int REGION_W   = 4,
  parameter int ERR_CODE_W = 2,
  parameter int REVISION   = 1,
  localparam int EW        = 1 << ERR_CODE_W,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [2:0]            reg_addr,
  input  logic [63:0]           reg_wdata,
  output logic [63:0]           reg_rdata,
  output logic                  snk_valid,
  input  logic                  snk_ready,
  output logic [31:0]           snk_data,
  output logic [REGION_W-1:0]   snk_region,
  output logic                  snk_push_done,
  input  logic                  snk_finish,
  input  logic [ERR_CODE_W-1:0] snk_err_code
);
  hstate_e             state_q;
  logic [REGION_W-1:0] region_q;
  logic                rst_req_q, ack_q, flush, finish_ok;
  logic                ctrl_wr, data_wr, err_wr, loading, has_credit;
  logic                ovf, push, pop, fifo_empty;
  logic [CW-1:0]       fifo_cnt, credit;
  logic [EW-1:0]       set_vec, clr_vec, err_q;

  assign ctrl_wr    = reg_wr && (reg_addr == A_CTRL);
  assign data_wr    = reg_wr && (reg_addr == A_DATA);
  assign err_wr     = reg_wr && (reg_addr == A_ERR);
  assign loading    = (state_q == HS_LOAD);
  assign credit     = CW'(DEPTH) - fifo_cnt;
  assign has_credit = (credit != '0);
  assign ovf        = data_wr && !(loading && has_credit);
  assign push       = data_wr && loading && has_credit && (reg_wdata != '0);
  assign pop        = snk_valid && snk_ready;

  always_comb begin
    set_vec    = '0;
    set_vec[0] = ovf;
    if (finish_ok && (snk_err_code != '0)) set_vec = set_vec | (EW'(1) << snk_err_code);
    clr_vec = err_wr ? reg_wdata[EW-1:0] : '0;
  end

  prc_seq #(.REGION_W(REGION_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .wr_rst(reg_wdata[C_RST]), .wr_start(reg_wdata[C_START]),
    .wr_push(reg_wdata[C_PUSH]), .wr_region(reg_wdata[C_REG_LO +: REGION_W]),
    .fifo_empty(fifo_empty), .snk_finish(snk_finish),
    .state_q(state_q), .region_q(region_q), .rst_req_q(rst_req_q),
    .ack_q(ack_q), .flush(flush), .finish_ok(finish_ok)
  );

  prc_word_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
    .wdata(reg_wdata[31:0]), .pop(pop), .rdata(snk_data),
    .empty(fifo_empty), .count(fifo_cnt)
  );

  prc_err_log #(.EW(EW)) u_err (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .err_q(err_q)
  );

  assign snk_valid     = !fifo_empty;
  assign snk_region    = region_q;
  assign snk_push_done = (state_q == HS_DRAIN) && fifo_empty;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_HDR:  reg_rdata[7:0] = 8'(REVISION);
      A_CTRL: begin
        reg_rdata[C_RST]   = rst_req_q;
        reg_rdata[C_ACK]   = ack_q;
        reg_rdata[C_START] = (state_q == HS_LOAD) || (state_q == HS_DRAIN);
        reg_rdata[C_PUSH]  = (state_q == HS_DRAIN);
        reg_rdata[C_REG_LO +: REGION_W] = region_q;
      end
      A_STAT: begin
        reg_rdata[1:0]             = state_q;
        reg_rdata[S_ERRF]          = |err_q;
        reg_rdata[S_CRD_LO +: CW]  = credit;
      end
      A_ERR:  reg_rdata[EW-1:0] = err_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/prc_host_chk.sv
module prc_host_chk
  import prc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int EW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic [1:0]    state,
  input logic          snk_valid,
  input logic          snk_ready,
  input logic [31:0]   snk_data,
  input logic          snk_push_done,
  input logic          flush,
  input logic          data_wr,
  input logic          ovf,
  input logic [EW-1:0] clr_vec,
  input logic [EW-1:0] err_q
);
  // R5
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R4
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready && !flush) |=> (snk_valid && $stable(snk_data)));

  // R3
  valid_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid |-> (state == HS_LOAD || state == HS_DRAIN));

  // R7
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && state != HS_LOAD) |=> err_q[0]);

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snk_push_done |-> !snk_valid);

  // R2
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state == HS_RESET && cnt == '0));

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[0] && !ovf) |=> !err_q[0]);
endmodule

bind prc_host prc_host_chk #(.DEPTH(DEPTH), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(fifo_cnt), .state(state_q),
  .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
  .snk_push_done(snk_push_done), .flush(flush), .data_wr(data_wr),
  .ovf(ovf), .clr_vec(clr_vec), .err_q(err_q)
);

// File: tb/prc_host_bench.sv
module prc_host_bench;
  import prc_pkg::*;
  localparam int DEPTH = 16;
  localparam int RW    = 4;
  localparam int EC    = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [2:0]    reg_addr;
  logic [63:0]   reg_wdata;
  logic [63:0]   reg_rdata;
  logic          snk_valid, snk_ready, snk_push_done, snk_finish;
  logic [31:0]   snk_data;
  logic [RW-1:0] snk_region;
  logic [EC-1:0] snk_err_code;

  always #4 clk = ~clk;

  prc_host #(.DEPTH(DEPTH), .REGION_W(RW), .ERR_CODE_W(EC)) u_prc_host (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snk_valid(snk_valid),
    .snk_ready(snk_ready), .snk_data(snk_data), .snk_region(snk_region),
    .snk_push_done(snk_push_done), .snk_finish(snk_finish),
    .snk_err_code(snk_err_code)
  );

  int n_cmp = 0, n_bad = 0;
  bit fin_flag = 0, mon_on = 0;
  int m_state = 0, m_credit = DEPTH, m_err = 0, m_rst = 0, m_region = 0;
  int ready_mode = 0;
  logic [31:0] q[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] stat_exp();
    return 64'(m_state) | (64'(m_err != 0) << 2) | (64'(m_credit) << 16);
  endfunction

  function automatic logic [63:0] ctrl_exp(input int ack);
    return 64'(m_rst) | (64'(ack) << 1) | (64'(m_state >= 2) << 8) |
           (64'(m_state == 3) << 9) | (64'(m_region) << 16);
  endfunction

  always @(negedge clk) begin
    snk_ready = (ready_mode == 1) || (ready_mode == 2 && !snk_ready);
  end

  // stream monitor: compared every clock against the behavioural queue
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      check("R4 valid", 64'(snk_valid), 64'(q.size() != 0));
      check("R8 push_done", 64'(snk_push_done), 64'(m_state == 3 && q.size() == 0));
      if (snk_valid && q.size() != 0) check("R4 data", 64'(snk_data), 64'(q[0]));
      if (snk_valid && snk_ready && q.size() != 0) begin
        void'(q.pop_front());
        m_credit++;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    int ns, dcr, se, ce;
    bit pw, fl;
    @(negedge clk);
    ns = m_state; dcr = 0; se = 0; ce = 0; pw = 0; fl = 0;
    if (a == A_DATA) begin
      if (m_state != 2 || m_credit == 0) se = 1;
      else if (d != 0) begin pw = 1; dcr = 1; end
    end else if (a == A_CTRL) begin
      if (d[0]) begin ns = 1; fl = 1; end
      else if (m_state == 1) ns = 0;
      else if (m_state == 0 && d[8]) ns = 2;
      else if (m_state == 2 && d[9]) ns = 3;
    end else if (a == A_ERR) ce = int'(d[3:0]);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    if (a == A_CTRL) begin
      m_rst = int'(d[0]);
      if (m_state == 0 && ns == 2) m_region = int'(d[16 +: RW]);
    end
    m_state = ns;
    m_credit -= dcr;
    m_err = (m_err & ~ce) | se;
    if (pw) q.push_back(d[31:0]);
    if (fl) begin q.delete(); m_credit = DEPTH; end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk); #1;
    reg_addr = a; #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (snk_push_done) break;
    end
  endtask

  task automatic fin(input int code, input logic [3:0] clr);
    @(negedge clk);
    snk_finish = 1'b1; snk_err_code = EC'(code);
    if (clr != 0) begin reg_wr = 1'b1; reg_addr = A_ERR; reg_wdata = 64'(clr); end
    @(posedge clk); #1;
    m_err = (m_err & ~int'(clr)) | ((code != 0) ? (1 << code) : 0);
    m_state = 0;
    @(negedge clk);
    snk_finish = 1'b0; snk_err_code = '0; reg_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    snk_ready = 1'b0; snk_finish = 1'b0; snk_err_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;

    // R1 / R11: reset state and header
    rd(A_HDR, 64'd1, "R11 revision");
    rd(A_CTRL, 64'd0, "R1 control");
    rd(A_STAT, stat_exp(), "R1 status");
    rd(A_ERR, 64'd0, "R1 error");

    // R7: data write outside an operation
    wr(A_DATA, 64'h1234);
    rd(A_ERR, 64'd1, "R7 idle write");
    rd(A_STAT, stat_exp(), "R7 flag");
    wr(A_ERR, 64'd1);
    rd(A_ERR, 64'd0, "R10 clear");

    // R2: reset handshake
    wr(A_CTRL, 64'd1);
    rd(A_CTRL, ctrl_exp(1), "R2 ack");
    rd(A_STAT, stat_exp(), "R2 reset state");
    wr(A_CTRL, 64'd0);
    rd(A_CTRL, ctrl_exp(0), "R2 release");
    rd(A_STAT, stat_exp(), "R2 idle");

    // R3: start on region 5
    wr(A_CTRL, (64'd1 << 8) | (64'd5 << 16));
    rd(A_CTRL, ctrl_exp(0), "R3 start");
    check("R3 region", 64'(snk_region), 64'd5);

    // R6: padding word
    wr(A_DATA, 64'd0);
    rd(A_STAT, stat_exp(), "R6 padding");
    check("R6 credit", 64'(m_credit), 64'(DEPTH));

    // R4: fill all credits with the sink stalled
    for (int i = 0; i < DEPTH; i++) wr(A_DATA, 64'hA000_0000 + 64'(i + 1));
    rd(A_STAT, stat_exp(), "R4 credit zero");
    check("R4 model credit", 64'(m_credit), 64'd0);

    // R7: write with no credit left
    wr(A_DATA, 64'hBEEF);
    rd(A_ERR, 64'd1, "R7 no credit");
    wr(A_ERR, 64'd1);

    // R5: credits return as the sink drains
    ready_mode = 1;
    repeat (DEPTH + 4) @(negedge clk);
    rd(A_STAT, stat_exp(), "R5 credit back");
    check("R5 full", 64'(m_credit), 64'(DEPTH));

    // R8 / R9 / R10: toggling sink, trailing padding, finish collides with clear
    ready_mode = 2;
    for (int i = 0; i < 6; i++) wr(A_DATA, 64'h5500_0000 + 64'(i * 3 + 7));
    wr(A_DATA, 64'd0);
    wr(A_DATA, 64'd0);
    wr(A_CTRL, 64'd1 << 9);
    wait_done();
    rd(A_CTRL, ctrl_exp(0), "R8 drain");
    fin(2, 4'b0100);
    rd(A_ERR, 64'd4, "R10 set wins");
    rd(A_CTRL, ctrl_exp(0), "R8 start released");
    rd(A_STAT, stat_exp(), "R9 status");
    wr(A_ERR, 64'd4);

    // R9: code 3 on a second operation
    ready_mode = 1;
    wr(A_CTRL, (64'd1 << 8) | (64'd3 << 16));
    for (int i = 0; i < 3; i++) wr(A_DATA, 64'h0C00_0000 + 64'(i));
    wr(A_CTRL, 64'd1 << 9);
    wait_done();
    fin(3, 4'b0000);
    rd(A_ERR, 64'd8, "R9 code 3");
    wr(A_ERR, 64'hF);

    // R9: code 0 leaves the error word clear
    wr(A_CTRL, (64'd1 << 8) | (64'd9 << 16));
    wr(A_DATA, 64'h77);
    wr(A_CTRL, 64'd1 << 9);
    wait_done();
    fin(0, 4'b0000);
    rd(A_ERR, 64'd0, "R9 code 0");
    check("R3 region 9", 64'(snk_region), 64'd9);

    // R2: reset request flushes queued words
    ready_mode = 0;
    wr(A_CTRL, (64'd1 << 8) | (64'd1 << 16));
    for (int i = 0; i < 4; i++) wr(A_DATA, 64'h1000 + 64'(i));
    rd(A_STAT, stat_exp(), "R4 partial credit");
    wr(A_CTRL, 64'd1);
    rd(A_STAT, stat_exp(), "R2 flush credit");
    rd(A_CTRL, ctrl_exp(1), "R2 ack again");
    check("R2 no valid", 64'(snk_valid), 64'd0);
    wr(A_CTRL, 64'd0);
    rd(A_STAT, stat_exp(), "R2 idle again");

    fin_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule